// File: doc/BRIEF.md
# Inter-Core Interrupt Register Bank

This block holds one set of interrupt source flags for each core. Any bus master can use it to interrupt a core. Each core has two register addresses, and both show the same flag field. A write to the *raise* address sets flags wherever the data has a 1. It can also fire a one-cycle interrupt pulse to that core. A write to the *acknowledge* address clears flags wherever the data has a 1. The receiving core reads either address to learn which sources want attention. It then acknowledges the sources it has handled. What each flag means is left to software.

The block has `WR_PORTS` independent write ports, so two masters can write in the same cycle. Writes from all ports are merged in that cycle. When one port sets a flag and another clears the same flag, the set wins. Readback is combinational on a separate read address.

The write and read address is `{view, core}`:
- The top bit selects the view: 0 is raise, 1 is acknowledge.
- The lower `$clog2(NUM_CORES)` bits select the core.

Top module: `ipc_irq_bank`

## Requirements
- R1: A raise write with data bit 0 = 1 to core x drives `irq_pulse[x]` high for exactly the one cycle after the write edge. The pulse then returns low unless another trigger arrives.
- R2: A raise write with data bit 0 = 0 produces no pulse. Bit 0 of a raise address always reads 0.
- R3: In a raise write, each 1 in data bits 31:4 sets the matching flag of that core, and each 0 leaves it unchanged. The new value is readable in the cycle after the write edge.
- R4: In an acknowledge write, each 1 in data bits 31:4 clears the matching flag of that core, and each 0 leaves it unchanged. Data bit 0 of an acknowledge write never produces a pulse.
- R5: The raise address and the acknowledge address of a core both read the same flags in bits 31:4. Bits 3:0 of both views read as zero, whatever was written to them.
- R6: During and after reset, all flags are 0 and no pulse is driven.
- R7: If a set and a clear for the same flag arrive in the same cycle, from different ports, the flag ends up set.
- R8: A single raise write that carries both flag bits and bit 0 = 1 updates the flags and fires the pulse on the same edge.
- R9: A write addressed to core x changes neither the flags nor the pulse of any other core.
- R10: Trigger writes from several ports in one cycle produce one pulse on every addressed core. This holds both when they address the same core and when they address different cores.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | WR_PORTS | Write strobe per port |
| wr_addr | input | WR_PORTS*ADDR_W | Per-port address `{view, core}`, port p in slice p |
| wr_data | input | WR_PORTS*DATA_W | Per-port write data, port p in slice p |
| rd_addr | input | ADDR_W | Read address `{view, core}` |
| rd_data | output | DATA_W | Read data: flags in bits 31:4, zeros elsewhere |
| irq_pulse | output | NUM_CORES | One-cycle interrupt pulse per core |

## Verification
Writes are presented between clock edges and take effect on the next rising edge. Both the flag state and `irq_pulse` are therefore due exactly one cycle after the write is presented. The bench checks them a few time units after that edge, and a pulse that lasts longer fails the comparison on the following cycle. Readback is combinational from the registered flags. In every cycle, after the edge, the bench sweeps all raise and acknowledge addresses and compares each one with its reference model before it presents the next write.

// File: rtl/ipc_irq_pkg.sv
package ipc_irq_pkg;

   // top address bit: which view of the shared flag field a write targets
   typedef enum logic {
      VIEW_RAISE = 1'b0,
      VIEW_ACK   = 1'b1
   } ipc_view_e;

   // width of the core index field, at least one bit
   function automatic int idx_width(int n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/ipc_wr_decode.sv
module ipc_wr_decode
   import ipc_irq_pkg::*;
#(
   parameter  int NUM_CORES = 8,
   parameter  int WR_PORTS  = 2,
   parameter  int DATA_W    = 32,
   parameter  int SRC_LSB   = 4,
   parameter  int SRC_W     = 28,
   localparam int IDX_W     = idx_width(NUM_CORES),
   localparam int ADDR_W    = IDX_W + 1
) (
   input  logic [WR_PORTS-1:0]                wr_en,
   input  logic [WR_PORTS*ADDR_W-1:0]         wr_addr,
   input  logic [WR_PORTS*DATA_W-1:0]         wr_data,
   output logic [NUM_CORES-1:0][SRC_W-1:0]    set_mask,
   output logic [NUM_CORES-1:0][SRC_W-1:0]    clr_mask,
   output logic [NUM_CORES-1:0]               trig
);

   ipc_view_e          p_view [WR_PORTS];
   logic [IDX_W-1:0]   p_idx  [WR_PORTS];
   logic [SRC_W-1:0]   p_src  [WR_PORTS];
   logic               p_trig [WR_PORTS];
   logic [WR_PORTS-1:0] unused_data;

   // split each flattened port into its fields
   for (genvar p = 0; p < WR_PORTS; p++) begin : g_port
      assign p_view[p]      = ipc_view_e'(wr_addr[p*ADDR_W + ADDR_W - 1]);
      assign p_idx[p]       = wr_addr[p*ADDR_W +: IDX_W];
      assign p_src[p]       = wr_data[p*DATA_W + SRC_LSB +: SRC_W];
      assign p_trig[p]      = wr_data[p*DATA_W];
      assign unused_data[p] = ^wr_data[p*DATA_W +: DATA_W];
   end

   // merge all ports into per-core set, clear and trigger requests
   always_comb begin
      set_mask = '0;
      clr_mask = '0;
      trig     = '0;
      for (int p = 0; p < WR_PORTS; p++) begin
         for (int c = 0; c < NUM_CORES; c++) begin
            if (wr_en[p] && (int'(p_idx[p]) == c)) begin
               if (p_view[p] == VIEW_RAISE) begin
                  set_mask[c] = set_mask[c] | p_src[p];
                  trig[c]     = trig[c] | p_trig[p];
               end else begin
                  clr_mask[c] = clr_mask[c] | p_src[p];
               end
            end
         end
      end
   end

endmodule

// File: rtl/ipc_src_bank.sv
module ipc_src_bank #(
   parameter int NUM_CORES = 8,
   parameter int SRC_W     = 28
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic [NUM_CORES-1:0][SRC_W-1:0]  set_mask,
   input  logic [NUM_CORES-1:0][SRC_W-1:0]  clr_mask,
   output logic [NUM_CORES-1:0][SRC_W-1:0]  src_state
);

   for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
      logic [SRC_W-1:0] flags_q;

      // clear first, then set: a set in the same cycle wins
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) flags_q <= '0;
         else        flags_q <= (flags_q & ~clr_mask[c]) | set_mask[c];
      end

      assign src_state[c] = flags_q;
   end

endmodule

// File: rtl/ipc_pulse_out.sv
module ipc_pulse_out #(
   parameter int NUM_CORES = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_CORES-1:0] trig,
   output logic [NUM_CORES-1:0] irq_pulse
);

   for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
      logic pulse_q;

      // high for one cycle per trigger cycle
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pulse_q <= 1'b0;
         else        pulse_q <= trig[c];
      end

      assign irq_pulse[c] = pulse_q;
   end

endmodule

// File: rtl/ipc_read_mux.sv
module ipc_read_mux
   import ipc_irq_pkg::*;
#(
   parameter  int NUM_CORES = 8,
   parameter  int DATA_W    = 32,
   parameter  int SRC_LSB   = 4,
   parameter  int SRC_W     = 28,
   localparam int IDX_W     = idx_width(NUM_CORES),
   localparam int ADDR_W    = IDX_W + 1
) (
   input  logic [ADDR_W-1:0]                rd_addr,
   input  logic [NUM_CORES-1:0][SRC_W-1:0]  src_state,
   output logic [DATA_W-1:0]                rd_data
);

   logic [IDX_W-1:0] rd_idx;
   logic             unused_view;

   assign rd_idx      = rd_addr[IDX_W-1:0];
   // both views return the same flags; trigger and reserved bits read 0
   assign unused_view = rd_addr[ADDR_W-1];

   always_comb begin
      rd_data = '0;
      for (int c = 0; c < NUM_CORES; c++) begin
         if (int'(rd_idx) == c) rd_data[SRC_LSB +: SRC_W] = src_state[c];
      end
   end

endmodule

// File: rtl/ipc_irq_bank.sv
module ipc_irq_bank
   import ipc_irq_pkg::*;
#(
   parameter  int NUM_CORES = 8,
   parameter  int WR_PORTS  = 2,
   parameter  int DATA_W    = 32,
   parameter  int SRC_LSB   = 4,
   parameter  int SRC_W     = 28,
   localparam int IDX_W     = idx_width(NUM_CORES),
   localparam int ADDR_W    = IDX_W + 1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [WR_PORTS-1:0]           wr_en,
   input  logic [WR_PORTS*ADDR_W-1:0]    wr_addr,
   input  logic [WR_PORTS*DATA_W-1:0]    wr_data,
   input  logic [ADDR_W-1:0]             rd_addr,
   output logic [DATA_W-1:0]             rd_data,
   output logic [NUM_CORES-1:0]          irq_pulse
);

   // elaboration-time parameter checks
   if (NUM_CORES < 2) begin : g_bad_cores
      $error("ipc_irq_bank: NUM_CORES must be at least 2");
   end
   if (WR_PORTS < 1) begin : g_bad_ports
      $error("ipc_irq_bank: WR_PORTS must be at least 1");
   end
   if (SRC_LSB < 1) begin : g_bad_lsb
      $error("ipc_irq_bank: bit 0 is the trigger, SRC_LSB must be >= 1");
   end
   if (SRC_LSB + SRC_W > DATA_W) begin : g_bad_width
      $error("ipc_irq_bank: flag field does not fit in DATA_W");
   end

   logic [NUM_CORES-1:0][SRC_W-1:0] set_mask;
   logic [NUM_CORES-1:0][SRC_W-1:0] clr_mask;
   logic [NUM_CORES-1:0][SRC_W-1:0] src_state;
   logic [NUM_CORES-1:0]            trig;

   ipc_wr_decode #(
      .NUM_CORES (NUM_CORES),
      .WR_PORTS  (WR_PORTS),
      .DATA_W    (DATA_W),
      .SRC_LSB   (SRC_LSB),
      .SRC_W     (SRC_W)
   ) u_decode (
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .set_mask (set_mask),
      .clr_mask (clr_mask),
      .trig     (trig)
   );

   ipc_src_bank #(
      .NUM_CORES (NUM_CORES),
      .SRC_W     (SRC_W)
   ) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_mask  (set_mask),
      .clr_mask  (clr_mask),
      .src_state (src_state)
   );

   ipc_pulse_out #(
      .NUM_CORES (NUM_CORES)
   ) u_pulse (
      .clk       (clk),
      .rst_n     (rst_n),
      .trig      (trig),
      .irq_pulse (irq_pulse)
   );

   ipc_read_mux #(
      .NUM_CORES (NUM_CORES),
      .DATA_W    (DATA_W),
      .SRC_LSB   (SRC_LSB),
      .SRC_W     (SRC_W)
   ) u_read (
      .rd_addr   (rd_addr),
      .src_state (src_state),
      .rd_data   (rd_data)
   );

endmodule

// File: rtl/ipc_irq_bank_chk.sv
module ipc_irq_bank_chk
   import ipc_irq_pkg::*;
#(
   parameter  int NUM_CORES = 8,
   parameter  int WR_PORTS  = 2,
   parameter  int DATA_W    = 32,
   parameter  int SRC_LSB   = 4,
   parameter  int SRC_W     = 28,
   localparam int IDX_W     = idx_width(NUM_CORES),
   localparam int ADDR_W    = IDX_W + 1
) (
   input logic                             clk,
   input logic                             rst_n,
   input logic [WR_PORTS-1:0]              wr_en,
   input logic [WR_PORTS*ADDR_W-1:0]       wr_addr,
   input logic [WR_PORTS*DATA_W-1:0]       wr_data,
   input logic [DATA_W-1:0]                rd_data,
   input logic [NUM_CORES-1:0]             irq_pulse,
   input logic [NUM_CORES-1:0][SRC_W-1:0]  src_state
);

   logic [NUM_CORES-1:0][SRC_W-1:0] want_set, want_clr, set_q, clr_q, prev_q;
   logic [NUM_CORES-1:0]            want_trig, trig_q;
   logic                            valid_q;

   // requests seen at the ports in this cycle
   always_comb begin
      want_set  = '0;
      want_clr  = '0;
      want_trig = '0;
      for (int p = 0; p < WR_PORTS; p++) begin
         if (wr_en[p]) begin
            for (int c = 0; c < NUM_CORES; c++) begin
               if (int'(wr_addr[p*ADDR_W +: IDX_W]) == c) begin
                  if (wr_addr[p*ADDR_W + ADDR_W - 1]) begin
                     want_clr[c] = want_clr[c] | wr_data[p*DATA_W + SRC_LSB +: SRC_W];
                  end else begin
                     want_set[c]  = want_set[c] | wr_data[p*DATA_W + SRC_LSB +: SRC_W];
                     want_trig[c] = want_trig[c] | wr_data[p*DATA_W];
                  end
               end
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         set_q   <= '0;
         clr_q   <= '0;
         trig_q  <= '0;
         prev_q  <= '0;
         valid_q <= 1'b0;
      end else begin
         set_q   <= want_set;
         clr_q   <= want_clr;
         trig_q  <= want_trig;
         prev_q  <= src_state;
         valid_q <= 1'b1;
      end
   end

   for (genvar c = 0; c < NUM_CORES; c++) begin : g_chk
      assert_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
         irq_pulse[c] == trig_q[c]);
      assert_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
         valid_q |-> ((src_state[c] & set_q[c]) == set_q[c]));
      assert_clr_R4: assert property (@(posedge clk) disable iff (!rst_n)
         valid_q |-> ((src_state[c] & clr_q[c] & ~set_q[c]) == '0));
      assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
         valid_q |-> ((set_q[c] & clr_q[c] & ~src_state[c]) == '0));
      assert_untouched_R9: assert property (@(posedge clk) disable iff (!rst_n)
         valid_q |-> (((src_state[c] ^ prev_q[c]) & ~(set_q[c] | clr_q[c])) == '0));
   end

   assert_reserved_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data[SRC_LSB-1:0] == '0);

   always_comb begin
      if (!rst_n) begin
         assert_reset_R6: assert (irq_pulse == '0);
      end
   end

endmodule

bind ipc_irq_bank ipc_irq_bank_chk #(
   .NUM_CORES (NUM_CORES),
   .WR_PORTS  (WR_PORTS),
   .DATA_W    (DATA_W),
   .SRC_LSB   (SRC_LSB),
   .SRC_W     (SRC_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr_en     (wr_en),
   .wr_addr   (wr_addr),
   .wr_data   (wr_data),
   .rd_data   (rd_data),
   .irq_pulse (irq_pulse),
   .src_state (src_state)
);

// File: tb/test_ipc_irq_bank.sv
`timescale 1ns/100ps
module test_ipc_irq_bank;

   localparam int CLK_PERIOD = 100;
   localparam int NC  = 8;
   localparam int NP  = 2;
   localparam int DW  = 32;
   localparam int SW  = 28;
   localparam int AW  = 4;
   localparam int WATCHDOG_CYCLES = 50000;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [NP-1:0]   wr_en = '0;
   logic [NP*AW-1:0] wr_addr = '0;
   logic [NP*DW-1:0] wr_data = '0;
   logic [AW-1:0]   rd_addr = '0;
   logic [DW-1:0]   rd_data;
   logic [NC-1:0]   irq_pulse;

   int compared = 0;
   int mismatched = 0;
   bit finished = 1'b0;
   string cur_req = "R6";

   // reference model state
   logic [SW-1:0] m_src [NC];
   logic [NC-1:0] m_pulse;

   always #(CLK_PERIOD/2) clk = ~clk;

   ipc_irq_bank i_ipc_irq_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .rd_addr   (rd_addr),
      .rd_data   (rd_data),
      .irq_pulse (irq_pulse)
   );

   task automatic put(input int p, input bit ack, input int core,
                      input logic [SW-1:0] src, input logic [3:0] low);
      wr_en[p] = 1'b1;
      wr_addr[p*AW +: AW] = {ack, 3'(core)};
      wr_data[p*DW +: DW] = {src, low};
   endtask

   task automatic compare_all();
      compared++;
      if (irq_pulse !== m_pulse) begin
         mismatched++;
         $display("FAIL %s irq_pulse actual=%b expected=%b", cur_req, irq_pulse, m_pulse);
      end
      for (int a = 0; a < 2*NC; a++) begin
         logic [DW-1:0] exp;
         rd_addr = AW'(a);
         #1;
         exp = {m_src[a % NC], 4'b0000};
         compared++;
         if (rd_data !== exp) begin
            mismatched++;
            $display("FAIL %s readback addr=%0d actual=%h expected=%h", cur_req, a, rd_data, exp);
         end
      end
   endtask

   // model computes next state from the presented writes, then the edge, then compare
   task automatic tick();
      logic [SW-1:0] s [NC];
      logic [SW-1:0] k [NC];
      logic [NC-1:0] t;
      for (int c = 0; c < NC; c++) begin s[c] = '0; k[c] = '0; end
      t = '0;
      for (int p = 0; p < NP; p++) begin
         if (wr_en[p]) begin
            int core;
            core = int'(wr_addr[p*AW +: 3]);
            if (wr_addr[p*AW + 3]) k[core] |= wr_data[p*DW + 4 +: SW];
            else begin
               s[core] |= wr_data[p*DW + 4 +: SW];
               t[core] |= wr_data[p*DW];
            end
         end
      end
      @(posedge clk);
      for (int c = 0; c < NC; c++) m_src[c] = (m_src[c] & ~k[c]) | s[c];
      m_pulse = t;
      #5;
      compare_all();
      wr_en = '0;
      wr_addr = '0;
      wr_data = '0;
   endtask

   task automatic report();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   endtask

   initial begin
      repeat (WATCHDOG_CYCLES) @(posedge clk);
      if (!finished) begin
         mismatched++;
         $display("FAIL watchdog expired during %s", cur_req);
         report();
      end
   end

   initial begin
      for (int c = 0; c < NC; c++) m_src[c] = '0;
      m_pulse = '0;

      // R6: state while in reset, even with writes presented
      cur_req = "R6";
      put(0, 1'b0, 2, 28'hFFFFFFF, 4'h1);
      repeat (3) @(posedge clk);
      #5;
      compare_all();
      wr_en = '0; wr_addr = '0; wr_data = '0;
      @(negedge clk);
      rst_n = 1'b1;
      tick();

      // R1: trigger core 3, pulse one cycle then low
      cur_req = "R1";
      put(0, 1'b0, 3, '0, 4'h1);
      tick();
      tick();

      // R2: bit 0 clear, no pulse
      cur_req = "R2";
      put(0, 1'b0, 4, 28'h0000003, 4'h0);
      tick();

      // R3: accumulate flags on core 2
      cur_req = "R3";
      put(0, 1'b0, 2, 28'h00000F5, 4'h0);
      tick();
      put(1, 1'b0, 2, 28'h0A00000, 4'h0);
      tick();

      // R4: acknowledge clears only ones; ack bit 0 gives no pulse
      cur_req = "R4";
      put(0, 1'b1, 2, 28'h0000005, 4'h1);
      tick();

      // R5: reserved bits written with ones in both views read 0
      cur_req = "R5";
      put(0, 1'b1, 6, '0, 4'hF);
      put(1, 1'b0, 6, 28'h8000001, 4'hE);
      tick();

      // R7: set and clear same bits same cycle, set wins
      cur_req = "R7";
      put(0, 1'b0, 1, 28'h0000F00, 4'h0);
      tick();
      put(0, 1'b0, 1, 28'h00000FF, 4'h0);
      put(1, 1'b1, 1, 28'h00000F0, 4'h0);
      tick();
      put(0, 1'b1, 1, 28'h0000F0F, 4'h0);
      put(1, 1'b0, 1, 28'h0000003, 4'h0);
      tick();

      // R8: flags and trigger in one write
      cur_req = "R8";
      put(0, 1'b0, 0, 28'h1234567, 4'h1);
      tick();

      // R9: a write to core 7 leaves the other cores alone
      cur_req = "R9";
      put(1, 1'b0, 7, 28'hFFFFFFF, 4'h1);
      tick();
      put(0, 1'b1, 7, 28'hFFFFFFF, 4'h0);
      tick();

      // R10: two ports, different cores then the same core
      cur_req = "R10";
      put(0, 1'b0, 5, '0, 4'h1);
      put(1, 1'b0, 1, '0, 4'h1);
      tick();
      put(0, 1'b0, 5, 28'h0000010, 4'h1);
      put(1, 1'b0, 5, 28'h0000020, 4'h1);
      tick();
      tick();

      // mixed traffic on both ports
      cur_req = "R9 random";
      for (int n = 0; n < 300; n++) begin
         for (int p = 0; p < NP; p++) begin
            if ($urandom_range(0, 3) != 0) begin
               put(p, 1'($urandom_range(0, 1)), int'($urandom_range(0, NC-1)),
                   SW'($urandom & $urandom), 4'($urandom));
            end
         end
         tick();
      end

      finished = 1'b1;
      report();
   end

endmodule